// File: doc/BRIEF.md
# Dual Register-File Checksum Datapath

This block is a statically scheduled datapath with no program counter and no opcode. Each accepted instruction word carries one enable bit per operation, together with every register-file address, the mux selects and a W-bit immediate. The decode is therefore just a matter of slicing the word into fields. Register file A has one read port and one write port, and it feeds a decrement unit that writes back into A. Register file B also has one read port and one write port. It feeds a checksum unit, which does ones'-complement addition with end-around carry and writes back into B. The compare path checks a selected read port against the immediate for equality.

Several operations may issue in the same cycle. A fixed conflict table marks which pairs may not share a cycle. Compare and checksum both need the single read port of B and the immediate, so that pair is marked as a conflict. When an issued word enables a conflicting pair, the whole word is discarded and an illegal flag is raised one cycle later. All results are registered.

The instruction input is a valid/ready stream. `ins_ready` is held high, so the block never applies back-pressure, and one word is consumed on every clock edge where `ins_valid` is high. The result outputs carry a valid qualifier but have no ready. A consumer must therefore take `cmp_eq` and `sum_data` in the cycle where their valid is high.

Top module: `dualrf_csum_dp`

## Requirements
- R1: After reset, every entry of both register files is zero. `cmp_vld`, `cmp_eq`, `sum_vld` and `ill_o` are low.
- R2: `ins_ready` is high outside reset, and a word is consumed on every edge where `ins_valid` is high. In a cycle with `ins_valid` low, no state changes, and `cmp_vld`, `sum_vld` and `ill_o` are low one cycle later.
- R3: Decrement (enable bit 0) writes A[`ins_word[6:5]`] minus one, modulo 2^W, into A at address `ins_word[8:7]`. A read of entry 0 after a decrement of zero gives 0xFFFF.
- R4: Compare (enable bit 1) raises `cmp_vld` one cycle after issue. `cmp_eq` is then high exactly when the operand equals the immediate `ins_word[28:13]`. The operand is A[`ins_word[6:5]`] when select bit 3 is 1 and B[`ins_word[10:9]`] when it is 0. `cmp_eq` is low whenever `cmp_vld` is low.
- R5: Checksum (enable bit 2) forms the ones'-complement sum of B[`ins_word[10:9]`] and an addend. The addend is `din` when select bit 4 is 0 and the immediate when it is 1. The sum is written into B at address `ins_word[12:11]` and also appears on `sum_data`, with `sum_vld` high one cycle after issue. `sum_data` holds its value otherwise.
- R6: A carry out of the top bit of the checksum addition is added back into bit 0. For example, 0xFFFF plus 0x0001 gives 0x0001.
- R7: Decrement and checksum may issue in the same word. Both results take effect, and `ill_o` stays low.
- R8: A word that enables both compare and checksum is discarded entirely, including any decrement it also enables. No register file changes, `cmp_vld` and `sum_vld` stay low, and `ill_o` is high one cycle later.
- R9: A word with enable bits [2:0] all zero changes no state and leaves `ill_o` low.
- R10: Decrement and compare may issue in the same word. A compare that reads file A sees the value from before that cycle's write.
- R11: All reads return the contents from before the current edge, so a write becomes visible to a word issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction word present |
| ins_ready | output | 1 | Word accepted; high outside reset |
| ins_word | input | 5+4*log2(DEPTH)+W (29) | Enables, selects, addresses, immediate |
| din | input | W (16) | Streamed data word for the checksum addend |
| cmp_vld | output | 1 | Compare result valid |
| cmp_eq | output | 1 | Compare result: operand equals immediate |
| sum_vld | output | 1 | Checksum result valid |
| sum_data | output | W (16) | Last checksum result |
| ill_o | output | 1 | Previous word broke the conflict table |

## Verification
The hardest state to reach is file A. The only way to see it is through an equality compare, so a compare against a random immediate almost never reports a match and shows little. The stimulus therefore sets the immediate, about half the time, to the value the bench model predicts for the selected operand. Runs of decrements then produce visible matches and visible mismatches. The sweep steps through all 32 combinations of enable and select bits with random addresses. This covers a decrement issued together with a compare, which checks the read-before-write ordering. It also covers discarded conflicting words that also carry a decrement.

// File: rtl/dualrf_pkg.sv
package dualrf_pkg;
  localparam int N_OPS = 3;
  typedef enum int { OP_DEC = 0, OP_CMP = 1, OP_CSUM = 2 } op_e;
  // Pair (i,j) sits at bit i*N_OPS+j; compare and checksum share the B read port and the immediate.
  localparam logic [N_OPS*N_OPS-1:0] CONFLICT =
    (9'd1 << (OP_CMP*N_OPS + OP_CSUM)) | (9'd1 << (OP_CSUM*N_OPS + OP_CMP));
  localparam int CTRL_BITS = 5;
endpackage

// File: rtl/dualrf_regfile.sv
module dualrf_regfile #(
  parameter int W = 16,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (we && waddr == AW'(g))        mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dualrf_ocadd.sv
module dualrf_ocadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] raw;
  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/dualrf_legal.sv
module dualrf_legal
  import dualrf_pkg::*;
(
  input  logic [N_OPS-1:0] en,
  output logic             legal
);
  logic [N_OPS*N_OPS-1:0] hit;

  for (genvar i = 0; i < N_OPS; i++) begin : g_row
    for (genvar j = 0; j < N_OPS; j++) begin : g_col
      if (j > i) begin : g_pair
        assign hit[i*N_OPS+j] = en[i] & en[j] & CONFLICT[i*N_OPS+j];
      end else begin : g_none
        assign hit[i*N_OPS+j] = 1'b0;
      end
    end
  end

  assign legal = ~|hit;
endmodule

// File: rtl/dualrf_csum_dp.sv
module dualrf_csum_dp
  import dualrf_pkg::*;
#(
  parameter int W = 16,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = CTRL_BITS + 4*AW + W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [IW-1:0] ins_word,
  input  logic [W-1:0]  din,
  output logic          cmp_vld,
  output logic          cmp_eq,
  output logic          sum_vld,
  output logic [W-1:0]  sum_data,
  output logic          ill_o
);
  localparam int F_ARA = CTRL_BITS;
  localparam int F_AWA = F_ARA + AW;
  localparam int F_BRA = F_AWA + AW;
  localparam int F_BWA = F_BRA + AW;
  localparam int F_IMM = F_BWA + AW;

  // field decode
  logic [N_OPS-1:0] en;
  logic             cmp_from_a, add_from_imm;
  logic [AW-1:0]    a_ra, a_wa, b_ra, b_wa;
  logic [W-1:0]     imm;

  assign en           = ins_word[N_OPS-1:0];
  assign cmp_from_a   = ins_word[3];
  assign add_from_imm = ins_word[4];
  assign a_ra         = ins_word[F_ARA +: AW];
  assign a_wa         = ins_word[F_AWA +: AW];
  assign b_ra         = ins_word[F_BRA +: AW];
  assign b_wa         = ins_word[F_BWA +: AW];
  assign imm          = ins_word[F_IMM +: W];

  logic legal, go;
  dualrf_legal u_legal (.en(en), .legal(legal));

  assign ins_ready = rst_n;
  assign go        = ins_valid & legal;

  logic [W-1:0] rd_a, rd_b, dec_val, addend, sum_val, cmp_opnd;

  assign dec_val = rd_a - W'(1);

  dualrf_regfile #(.W(W), .DEPTH(DEPTH)) u_rf_a (
    .clk(clk), .rst_n(rst_n),
    .we(go & en[OP_DEC]), .waddr(a_wa), .wdata(dec_val),
    .raddr(a_ra), .rdata(rd_a)
  );

  assign addend = add_from_imm ? imm : din;

  dualrf_ocadd #(.W(W)) u_add (.a(rd_b), .b(addend), .y(sum_val));

  dualrf_regfile #(.W(W), .DEPTH(DEPTH)) u_rf_b (
    .clk(clk), .rst_n(rst_n),
    .we(go & en[OP_CSUM]), .waddr(b_wa), .wdata(sum_val),
    .raddr(b_ra), .rdata(rd_b)
  );

  assign cmp_opnd = cmp_from_a ? rd_a : rd_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld  <= 1'b0;
      cmp_eq   <= 1'b0;
      sum_vld  <= 1'b0;
      sum_data <= '0;
      ill_o    <= 1'b0;
    end else begin
      cmp_vld <= go & en[OP_CMP];
      cmp_eq  <= go & en[OP_CMP] & (cmp_opnd == imm);
      sum_vld <= go & en[OP_CSUM];
      if (go & en[OP_CSUM]) sum_data <= sum_val;
      ill_o   <= ins_valid & ~legal;
    end
  end
endmodule

// File: rtl/dualrf_csum_dp_chk.sv
module dualrf_csum_dp_chk #(
  parameter int IW = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic [IW-1:0] ins_word,
  input logic          cmp_vld,
  input logic          cmp_eq,
  input logic          sum_vld,
  input logic          ill_o
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> (!cmp_vld && !sum_vld && !ill_o));

  p_cmp_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[1] && !ins_word[2]) |=> cmp_vld);

  p_eq_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_eq |-> cmp_vld);

  p_dec_csum_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[0] && ins_word[2] && !ins_word[1]) |=> (sum_vld && !ill_o));

  p_conflict_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[1] && ins_word[2]) |=> (ill_o && !cmp_vld && !sum_vld));

  p_nop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[2:0] == 3'b000) |=> (!ill_o && !cmp_vld && !sum_vld));

  p_dec_cmp_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[0] && ins_word[1] && !ins_word[2]) |=> (cmp_vld && !ill_o));
endmodule

bind dualrf_csum_dp dualrf_csum_dp_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
  .cmp_vld(cmp_vld), .cmp_eq(cmp_eq), .sum_vld(sum_vld), .ill_o(ill_o)
);

// File: tb/dualrf_csum_dp_tb_top.sv
module dualrf_csum_dp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [28:0] ins_word = '0;
  logic [15:0] din = '0;
  logic        cmp_vld, cmp_eq, sum_vld, ill_o;
  logic [15:0] sum_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] ma [4];
  logic [15:0] mb [4];
  logic [15:0] exp_sum = '0;

  always #2 clk = ~clk;

  dualrf_csum_dp dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .din(din), .cmp_vld(cmp_vld), .cmp_eq(cmp_eq),
    .sum_vld(sum_vld), .sum_data(sum_data), .ill_o(ill_o)
  );

  function automatic logic [15:0] oc(input logic [15:0] a, input logic [15:0] b);
    int unsigned t;
    t = int'(a) + int'(b);
    if (t > 32'hFFFF) t = t - 32'h10000 + 1;
    return t[15:0];
  endfunction

  function automatic logic [28:0] mk(input logic [4:0] c, input logic [1:0] ara, input logic [1:0] awa,
                                     input logic [1:0] bra, input logic [1:0] bwa, input logic [15:0] imm);
    return {imm, bwa, bra, awa, ara, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [28:0] w, input logic [15:0] d);
    logic [1:0] ara, awa, bra, bwa;
    logic [15:0] imm, opnd, s, dv;
    logic lg, go, e_cv, e_eq, e_sv, e_ill, carry;
    string tc, ts, ti;
    @(negedge clk);
    ins_valid = v; ins_word = w; din = d;
    ara = w[6:5]; awa = w[8:7]; bra = w[10:9]; bwa = w[12:11]; imm = w[28:13];
    lg = !(w[1] && w[2]);
    go = v && lg;
    opnd = w[3] ? ma[ara] : mb[bra];
    e_cv = go && w[1];
    e_eq = e_cv && (opnd == imm);
    s = oc(mb[bra], w[4] ? imm : d);
    carry = (int'(mb[bra]) + int'(w[4] ? imm : d)) > 32'hFFFF;
    e_sv = go && w[2];
    if (e_sv) exp_sum = s;
    e_ill = v && !lg;
    dv = ma[ara] - 16'd1;
    if (go && w[0]) ma[awa] = dv;
    if (go && w[2]) mb[bwa] = s;
    tc = !v ? "R2" : (w[0] && w[1]) ? "R10" : w[3] ? "R3" : "R4";
    ts = !v ? "R2" : (w[0] && w[2]) ? "R7" : carry ? "R6" : "R5";
    ti = !v ? "R2" : !lg ? "R8" : (w[2:0] == 3'b000) ? "R9" : "R11";
    @(posedge clk);
    #1;
    chk(cmp_vld == e_cv, tc, "cmp_vld", 32'(cmp_vld), 32'(e_cv));
    chk(cmp_eq == e_eq, tc, "cmp_eq", 32'(cmp_eq), 32'(e_eq));
    chk(sum_vld == e_sv, ts, "sum_vld", 32'(sum_vld), 32'(e_sv));
    chk(sum_data == exp_sum, ts, "sum_data", 32'(sum_data), 32'(exp_sum));
    chk(ill_o == e_ill, ti, "ill_o", 32'(ill_o), 32'(e_ill));
    chk(ins_ready == 1'b1, "R2", "ins_ready", 32'(ins_ready), 32'd1);
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog act=%h exp=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(!cmp_vld && !cmp_eq && !sum_vld && !ill_o && sum_data == 0, "R1", "reset outputs",
        {27'd0, cmp_vld, cmp_eq, sum_vld, ill_o, 1'b0}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: files read zero after reset
    step(1, mk(5'b01010, 2'd3, 0, 0, 0, 16'h0000), 0);
    step(1, mk(5'b00010, 0, 0, 2'd2, 0, 16'h0000), 0);
    // R3: decrement of zero wraps to FFFF, seen by compare of A
    step(1, mk(5'b00001, 0, 0, 0, 0, 0), 0);
    step(1, mk(5'b01010, 0, 0, 0, 0, 16'hFFFF), 0);
    // R5/R6: FFFF then +0001 with end-around carry gives 0001
    step(1, mk(5'b00100, 0, 0, 0, 0, 0), 16'hFFFF);
    step(1, mk(5'b10100, 0, 0, 0, 0, 16'h0001), 0);
    step(1, mk(5'b00010, 0, 0, 0, 0, 16'h0001), 0);
    // R8: conflicting word with decrement is dropped entirely
    step(1, mk(5'b00111, 2'd1, 2'd1, 0, 0, 16'h0001), 16'h1234);
    step(1, mk(5'b01010, 2'd1, 0, 0, 0, 16'h0000), 0);
    // R2: idle cycle
    step(0, mk(5'b00111, 0, 0, 0, 0, 0), 0);

    for (int rep = 0; rep < 250; rep++) begin
      for (int c = 0; c < 32; c++) begin
        logic [1:0] ara, bra;
        logic [15:0] imm;
        logic v;
        ara = 2'($urandom_range(0, 3));
        bra = 2'($urandom_range(0, 3));
        imm = 16'($urandom);
        if ($urandom_range(0, 1) == 1) imm = c[3] ? ma[ara] : mb[bra];
        v = ($urandom_range(0, 7) != 0);
        step(v, mk(5'(c), ara, 2'($urandom_range(0, 3)), bra, 2'($urandom_range(0, 3)), imm),
             16'($urandom));
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule